// File: doc/BRIEF.md
# Command Response Receiver

This block listens to the serial command line of a memory card after the host has finished sending a command. It waits for the card's start bit and deserializes either a short 48-bit or a long 136-bit response frame. The length comes from a two-bit response-type field that is captured with the command-sent trigger. The block computes a CRC7 over the covered bits when the type asks for a check. It places the frame, most significant bit first, into a small FIFO of 16-bit halfwords that a bus reader drains one halfword per pop.

Three single-cycle pulses drive the host status register. One marks the end of the response, one marks a CRC mismatch and one marks a response timeout. A loadable limit bounds how many card-clock samples the block waits for the start bit. Command transmission and the data lines are handled elsewhere. This block only sees a one-cycle "command sent" strobe.

Top module: `cmd_resp_rx`

## Requirements
- R1: With response type 0 (no response), `endResp` is high in the cycle after `cmdSent` is sampled, `crcErr` and `timeoutErr` stay low, and the FIFO stays empty.
- R2: Types 1 and 3 take a 48-bit frame, start bit included, which is read out as three halfwords with the first received bit in bit 15 of halfword 0. The 32-bit card status is halfword0[7:0], halfword1, halfword2[15:8].
- R3: Type 2 takes a 136-bit frame. Its first 8 received bits are dropped and the remaining 128 bits are read out as eight halfwords, first received bit first. The last halfword ends with the 7 CRC bits followed by the end bit.
- R4: For type 1 the CRC7 (x^7+x^3+1, register cleared to 0, MSB-first) over the first 40 frame bits is compared with the 7 bits preceding the end bit. A mismatch pulses `crcErr` together with `endResp`.
- R5: For type 2 the same CRC7 covers the 120 bits between the 8 dropped bits and the CRC field. A mismatch pulses `crcErr` together with `endResp`.
- R6: For type 3 no CRC is checked, so `crcErr` stays low even when the CRC field is wrong.
- R7: The line is sampled only in cycles with `cardClkEn` high and after the `cmdSent` cycle. The first low sample is the start bit. Line values in cycles without `cardClkEn` have no effect.
- R8: While the block waits for the start bit, each high sample is counted. When the count reaches the limit (a limit of 0 acts as 1), `timeoutErr` and `endResp` pulse together. The limit resets to 255 and is loaded from `toWrData` when `toWrEn` is high.
- R9: `endResp` (and `crcErr` when due) is high in the cycle after the edge that samples the end bit, never earlier, and by then every halfword of the frame is in the FIFO.
- R10: `popData` shows the oldest halfword and a pop with `popReq` removes it. With the FIFO empty, `popData` is 0 and a pop changes nothing.
- R11: `cmdSent` empties the FIFO and abandons any response being waited for or received. Reception restarts for the new command.
- R12: A pop in the same cycle as a halfword is pushed takes effect along with the push, and the order of halfwords is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cardClkEn | input | 1 | One-cycle strobe marking a card clock sample point |
| cmdLine | input | 1 | Serial command line from the card |
| cmdSent | input | 1 | One-cycle trigger at the end of command transmission |
| respType | input | 2 | Response type captured with `cmdSent` (0 none, 1 short checked, 2 long, 3 short unchecked) |
| toWrEn | input | 1 | Load strobe for the start-bit wait limit |
| toWrData | input | 8 | New start-bit wait limit in card clock samples |
| popReq | input | 1 | Bus read of the response FIFO, removes the head entry |
| popData | output | 16 | Head halfword of the response FIFO, 0 when empty |
| endResp | output | 1 | Pulse: response complete, timed out, or no response expected |
| crcErr | output | 1 | Pulse: CRC7 mismatch on a checked response |
| timeoutErr | output | 1 | Pulse: no start bit within the wait limit |

## Verification
The deserializer pushes a finished halfword into the FIFO while the bus side may pop in the same cycle, and the two meet in the count and pointer update. The bench holds a pop on the card clock sample that completes the second halfword of a long response. At that moment only the first halfword is queued. The popped value must be that first halfword, and the seven halfwords that remain must then come out in order, followed by an empty read of 0. A second coincidence is a new command arriving mid-frame, where the flush must win over the pending push. The bench judges it by an empty read right after the trigger and a clean frame that follows.

// File: rtl/cmd_resp_rx_pkg.sv
package cmd_resp_rx_pkg;

  typedef enum logic [1:0] {
    RT_NONE      = 2'd0,
    RT_SHORT_CRC = 2'd1,
    RT_LONG      = 2'd2,
    RT_SHORT_RAW = 2'd3
  } respType_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_RECV
  } rxState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic flush;
    logic storeBit;
    logic crcUpd;
    logic pushWord;
  } rxStrobe_t;

  localparam int SHORT_BITS = 48;
  localparam int LONG_BITS  = 136;
  localparam int LONG_SKIP  = 8;
  localparam int CRC_W      = 7;
  localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;

  function automatic logic [CRC_W-1:0] crc7Step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = b ^ c[CRC_W-1];
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

endpackage

// File: rtl/cmd_resp_rx_fifo.sv
module cmd_resp_rx_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          flush,
  input  logic          wrEn,
  input  logic [DW-1:0] wrData,
  input  logic          rdEn,
  output logic [DW-1:0] rdData
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] cnt;
  logic          isEmpty, doPush, doPop;

  assign isEmpty = (cnt == '0);
  assign doPop   = rdEn && !isEmpty && !flush;
  assign doPush  = wrEn && !flush && ((cnt != FULL_CNT) || doPop);
  assign rdData  = isEmpty ? '0 : mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R12: a frame never needs more entries than the FIFO holds
  a_r12_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !flush && !(rdEn && !isEmpty)) |-> (cnt != FULL_CNT));

  // R10: empty FIFO reads as zero
  a_r10_empty_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    isEmpty |-> (rdData == '0));

  // R10: pop of an empty FIFO leaves the pointers alone
  a_r10_pop_empty_holds: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && isEmpty && !wrEn && !flush) |=> (isEmpty && $stable(rdPtr)));

  // R11: a flush leaves the FIFO empty
  a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> isEmpty);

endmodule

// File: rtl/cmd_resp_rx_dp.sv
module cmd_resp_rx_dp
  import cmd_resp_rx_pkg::*;
#(
  parameter int HW_W       = 16,
  parameter int FIFO_DEPTH = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  rxStrobe_t       strobe,
  input  logic            cmdBit,
  input  logic            popReq,
  output logic            crcMatch,
  output logic [HW_W-1:0] popData
);
  logic [HW_W-1:0]  shReg, shNext;
  logic [CRC_W-1:0] crcAcc;

  assign shNext   = {shReg[HW_W-2:0], cmdBit};
  // the CRC field sits just above the end bit once the last bit is shifted in
  assign crcMatch = (crcAcc == shNext[CRC_W:1]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      crcAcc <= '0;
    end else if (strobe.flush) begin
      shReg  <= '0;
      crcAcc <= '0;
    end else begin
      if (strobe.storeBit) shReg  <= shNext;
      if (strobe.crcUpd)   crcAcc <= crc7Step(crcAcc, cmdBit);
    end
  end

  cmd_resp_rx_fifo #(
    .DW   (HW_W),
    .DEPTH(FIFO_DEPTH)
  ) fifo_i (
    .clk   (clk),
    .rstN  (rstN),
    .flush (strobe.flush),
    .wrEn  (strobe.pushWord),
    .wrData(shNext),
    .rdEn  (popReq),
    .rdData(popData)
  );

  // CRC accumulation only ever happens on stored bits
  a_r4_crc_on_stored: assert property (@(posedge clk) disable iff (!rstN)
    strobe.crcUpd |-> strobe.storeBit);

endmodule

// File: rtl/cmd_resp_rx_ctrl.sv
module cmd_resp_rx_ctrl
  import cmd_resp_rx_pkg::*;
#(
  parameter int HW_W     = 16,
  parameter int TO_W     = 8,
  parameter int TO_RESET = 255
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cardClkEn,
  input  logic            cmdLine,
  input  logic            cmdSent,
  input  logic [1:0]      respType,
  input  logic            toWrEn,
  input  logic [TO_W-1:0] toWrData,
  input  logic            crcMatch,
  output rxStrobe_t       strobe,
  output logic            endResp,
  output logic            crcErr,
  output logic            timeoutErr
);
  localparam int IDX_W = $clog2(LONG_BITS);
  localparam int HB    = $clog2(HW_W);
  localparam logic [IDX_W-1:0] SHORT_LAST = IDX_W'(SHORT_BITS - 1);
  localparam logic [IDX_W-1:0] LONG_LAST  = IDX_W'(LONG_BITS - 1);
  localparam logic [IDX_W-1:0] SKIP_IDX   = IDX_W'(LONG_SKIP);
  localparam logic [TO_W-1:0]  TO_INIT    = TO_W'(TO_RESET);

  rxState_e        state;
  respType_e       newType;
  logic            isLong, chkCrc;
  logic [IDX_W-1:0] bitIdx, curIdx, lastIdx, skipIdx, covEnd;
  logic [HB-1:0]   payLow;
  logic [TO_W-1:0] waitCnt, toLimit;
  logic [TO_W:0]   nextWait;
  logic            waitHit, takeBit;
  logic            endQ, crcErrQ, toErrQ;

  assign newType = respType_e'(respType);

  always_comb begin
    lastIdx  = isLong ? LONG_LAST : SHORT_LAST;
    skipIdx  = isLong ? SKIP_IDX : '0;
    covEnd   = lastIdx - IDX_W'(CRC_W);
    curIdx   = (state == ST_RECV) ? bitIdx : '0;
    payLow   = HB'(curIdx - skipIdx);
    takeBit  = !cmdSent && cardClkEn &&
               (((state == ST_WAIT) && !cmdLine) || (state == ST_RECV));
    nextWait = {1'b0, waitCnt} + 1'b1;
    waitHit  = (nextWait >= {1'b0, toLimit});

    strobe.flush    = cmdSent;
    strobe.storeBit = takeBit && (curIdx >= skipIdx);
    strobe.crcUpd   = strobe.storeBit && (curIdx < covEnd);
    strobe.pushWord = strobe.storeBit && (payLow == '1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      isLong  <= 1'b0;
      chkCrc  <= 1'b0;
      bitIdx  <= '0;
      waitCnt <= '0;
      toLimit <= TO_INIT;
      endQ    <= 1'b0;
      crcErrQ <= 1'b0;
      toErrQ  <= 1'b0;
    end else begin
      endQ    <= 1'b0;
      crcErrQ <= 1'b0;
      toErrQ  <= 1'b0;
      if (toWrEn) toLimit <= toWrData;
      if (cmdSent) begin
        isLong  <= (newType == RT_LONG);
        chkCrc  <= (newType == RT_SHORT_CRC) || (newType == RT_LONG);
        waitCnt <= '0;
        bitIdx  <= '0;
        if (newType == RT_NONE) begin
          endQ  <= 1'b1;
          state <= ST_IDLE;
        end else begin
          state <= ST_WAIT;
        end
      end else if (cardClkEn) begin
        case (state)
          ST_WAIT: begin
            if (!cmdLine) begin
              state  <= ST_RECV;
              bitIdx <= IDX_W'(1);
            end else begin
              waitCnt <= nextWait[TO_W-1:0];
              if (waitHit) begin
                toErrQ <= 1'b1;
                endQ   <= 1'b1;
                state  <= ST_IDLE;
              end
            end
          end
          ST_RECV: begin
            if (bitIdx == lastIdx) begin
              endQ    <= 1'b1;
              crcErrQ <= chkCrc && !crcMatch;
              state   <= ST_IDLE;
            end else begin
              bitIdx <= bitIdx + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign endResp    = endQ;
  assign crcErr     = crcErrQ;
  assign timeoutErr = toErrQ;

  // R8: a timeout always ends the response phase
  a_r8_timeout_ends: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> endResp);

  // R4 / R5: CRC errors only end a checked response
  a_r4_crc_err_ends: assert property (@(posedge clk) disable iff (!rstN)
    crcErr |-> (endResp && chkCrc && !timeoutErr));

  // R6: unchecked types never flag a CRC error
  a_r6_raw_no_crc: assert property (@(posedge clk) disable iff (!rstN)
    !chkCrc |-> !crcErr);

  // R9: the bit counter stays inside the selected frame
  a_r9_idx_bounds: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RECV) |-> ((bitIdx != '0) && (bitIdx <= lastIdx)));

  // R7: nothing is sampled while a command trigger is present
  a_r7_no_take_on_trigger: assert property (@(posedge clk) disable iff (!rstN)
    cmdSent |-> !(strobe.storeBit || strobe.pushWord));

endmodule

// File: rtl/cmd_resp_rx.sv
module cmd_resp_rx
  import cmd_resp_rx_pkg::*;
#(
  parameter int HW_W       = 16,
  parameter int FIFO_DEPTH = 8,
  parameter int TO_W       = 8,
  parameter int TO_RESET   = 255
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cardClkEn,
  input  logic            cmdLine,
  input  logic            cmdSent,
  input  logic [1:0]      respType,
  input  logic            toWrEn,
  input  logic [TO_W-1:0] toWrData,
  input  logic            popReq,
  output logic [HW_W-1:0] popData,
  output logic            endResp,
  output logic            crcErr,
  output logic            timeoutErr
);
  rxStrobe_t strobe;
  logic      crcMatch;

  cmd_resp_rx_ctrl #(
    .HW_W    (HW_W),
    .TO_W    (TO_W),
    .TO_RESET(TO_RESET)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .cardClkEn (cardClkEn),
    .cmdLine   (cmdLine),
    .cmdSent   (cmdSent),
    .respType  (respType),
    .toWrEn    (toWrEn),
    .toWrData  (toWrData),
    .crcMatch  (crcMatch),
    .strobe    (strobe),
    .endResp   (endResp),
    .crcErr    (crcErr),
    .timeoutErr(timeoutErr)
  );

  cmd_resp_rx_dp #(
    .HW_W      (HW_W),
    .FIFO_DEPTH(FIFO_DEPTH)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cmdBit  (cmdLine),
    .popReq  (popReq),
    .crcMatch(crcMatch),
    .popData (popData)
  );

endmodule

// File: tb/cmd_resp_rx_tb_top.sv
module cmd_resp_rx_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cardClkEn = 1'b0;
  logic        cmdLine = 1'b1;
  logic        cmdSent = 1'b0;
  logic [1:0]  respType = 2'd0;
  logic        toWrEn = 1'b0;
  logic [7:0]  toWrData = 8'd0;
  logic        popReq = 1'b0;
  logic [15:0] popData;
  logic        endResp, crcErr, timeoutErr;

  int checks = 0;
  int fails  = 0;
  int early, sEnd, sCrc, sTo;
  logic [15:0] poppedAt;

  always #10 clk = ~clk;

  cmd_resp_rx dut_i (
    .clk(clk), .rstN(rstN), .cardClkEn(cardClkEn), .cmdLine(cmdLine),
    .cmdSent(cmdSent), .respType(respType), .toWrEn(toWrEn), .toWrData(toWrData),
    .popReq(popReq), .popData(popData), .endResp(endResp), .crcErr(crcErr),
    .timeoutErr(timeoutErr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] refCrc(input logic [135:0] f, input int top, input int n);
    logic [6:0] r = '0;
    for (int j = 0; j < n; j++) begin
      logic fb;
      fb = f[top - j] ^ r[6];
      r = {r[5:0], 1'b0};
      if (fb) r = r ^ 7'b0001001;
    end
    return r;
  endfunction

  function automatic logic [135:0] mk48(input logic [5:0] ix, input logic [31:0] st, input logic bad);
    logic [135:0] f = '0;
    logic [6:0] c;
    f[47:0] = {2'b00, ix, st, 7'h00, 1'b1};
    c = refCrc(f, 47, 40);
    if (bad) c = c ^ 7'h10;
    f[7:1] = c;
    return f;
  endfunction

  function automatic logic [135:0] mk136(input logic [119:0] pl, input logic bad);
    logic [135:0] f;
    logic [6:0] c;
    f = {8'h3F, pl, 7'h00, 1'b1};
    c = refCrc(f, 127, 120);
    if (bad) c = c ^ 7'h01;
    f[7:1] = c;
    return f;
  endfunction

  task automatic startCmd(input logic [1:0] t, output logic endSeen);
    @(negedge clk);
    cmdSent = 1'b1; respType = t;
    @(posedge clk); #1;
    endSeen = endResp;
    @(negedge clk);
    cmdSent = 1'b0;
  endtask

  // one enabled sample per bit, then a disabled cycle carrying the inverted bit
  task automatic sendBits(input logic [135:0] f, input int len, input int popAt);
    early = 0; sEnd = 0; sCrc = 0; sTo = 0;
    for (int idx = 0; idx < len; idx++) begin
      @(negedge clk);
      cmdLine = f[len - 1 - idx]; cardClkEn = 1'b1;
      popReq = (idx == popAt);
      if (idx == popAt) begin #1; poppedAt = popData; end
      @(posedge clk); #1;
      if (idx < len - 1) begin
        if (endResp || crcErr) early++;
      end else begin
        sEnd = endResp; sCrc = crcErr; sTo = timeoutErr;
      end
      @(negedge clk);
      cardClkEn = 1'b0; popReq = 1'b0; cmdLine = ~f[len - 1 - idx];
      @(posedge clk);
    end
    @(negedge clk);
    cmdLine = 1'b1;
  endtask

  // high samples while enabled, low line while disabled
  task automatic sendIdle(input int n, output int hitAt);
    hitAt = -1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cmdLine = 1'b1; cardClkEn = 1'b1;
      @(posedge clk); #1;
      if (timeoutErr && endResp && hitAt < 0) hitAt = k + 1;
      @(negedge clk);
      cardClkEn = 1'b0; cmdLine = 1'b0;
      @(posedge clk);
    end
    @(negedge clk);
    cmdLine = 1'b1;
  endtask

  task automatic popWord(output logic [15:0] v);
    @(negedge clk);
    popReq = 1'b1;
    #1 v = popData;
    @(posedge clk); #1;
    popReq = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10 reset popData", popData, 0);
    chk("R1 reset endResp", endResp, 0);
    chk("R4 reset crcErr", crcErr, 0);
    chk("R8 reset timeoutErr", timeoutErr, 0);
  endtask

  task automatic t_none;
    logic e;
    logic [15:0] v;
    startCmd(2'd0, e);
    chk("R1 endResp after trigger", e, 1);
    chk("R1 no timeout", timeoutErr, 0);
    chk("R1 no crc error", crcErr, 0);
    @(posedge clk); #1;
    chk("R1 single pulse", endResp, 0);
    popWord(v);
    chk("R1 fifo empty", v, 0);
  endtask

  task automatic t_short(input logic [1:0] t, input logic bad, input logic expCrc, input string tag);
    logic [135:0] f;
    logic [15:0] v [3];
    logic [15:0] z;
    logic e;
    int h;
    f = mk48(6'h11, 32'hA5C3_0F96, bad);
    startCmd(t, e);
    chk({tag, " R1 no end at trigger"}, e, 0);
    sendIdle(3, h);
    chk({tag, " R7 no timeout while idle"}, h, -1);
    sendBits(f, 48, -1);
    chk({tag, " R9 no early end"}, early, 0);
    chk({tag, " R9 end after end bit"}, sEnd, 1);
    chk({tag, " R4 crc flag"}, sCrc, expCrc);
    chk({tag, " R8 no timeout"}, sTo, 0);
    for (int k = 0; k < 3; k++) begin
      popWord(v[k]);
      chk({tag, " R2 halfword"}, v[k], f[47 - 16*k -: 16]);
    end
    chk({tag, " R2 card status"}, {v[0][7:0], v[1], v[2][15:8]}, 32'hA5C3_0F96);
    popWord(z);
    chk({tag, " R10 empty after drain"}, z, 0);
  endtask

  task automatic t_long(input logic bad, input int popAt);
    logic [135:0] f;
    logic [15:0] v;
    logic e;
    f = mk136(120'h0123_4567_89AB_CDEF_FEDC_BA98_7654_32, bad);
    startCmd(2'd2, e);
    sendBits(f, 136, popAt);
    chk("R9 long no early end", early, 0);
    chk("R3 long end", sEnd, 1);
    chk("R5 long crc flag", sCrc, bad ? 1 : 0);
    for (int k = (popAt >= 0) ? 1 : 0; k < 8; k++) begin
      popWord(v);
      chk("R3 long halfword", v, f[127 - 16*k -: 16]);
    end
    if (popAt >= 0) chk("R12 pop during push", poppedAt, f[127:112]);
    popWord(v);
    chk("R12 long empty after eight", v, 0);
  endtask

  task automatic t_timeout;
    logic e;
    int h;
    startCmd(2'd1, e);
    sendIdle(255, h);
    chk("R8 default limit 255", h, 255);
    @(negedge clk);
    toWrEn = 1'b1; toWrData = 8'd5;
    @(posedge clk); #1;
    toWrEn = 1'b0;
    startCmd(2'd3, e);
    sendIdle(6, h);
    chk("R8 limit 5 with low line while disabled (R7)", h, 5);
    @(negedge clk);
    toWrEn = 1'b1; toWrData = 8'd0;
    @(posedge clk); #1;
    toWrEn = 1'b0;
    startCmd(2'd1, e);
    sendIdle(1, h);
    chk("R8 limit 0 acts as 1", h, 1);
    @(negedge clk);
    toWrEn = 1'b1; toWrData = 8'd255;
    @(posedge clk); #1;
    toWrEn = 1'b0;
  endtask

  task automatic t_abort;
    logic [135:0] a, b;
    logic [15:0] v;
    logic e;
    a = mk48(6'h2A, 32'hDEAD_BEEF, 1'b0);
    b = mk48(6'h05, 32'h1357_9BDF, 1'b0);
    startCmd(2'd1, e);
    sendBits(a, 20, -1);
    chk("R11 partial no end", early, 0);
    startCmd(2'd1, e);
    chk("R11 fifo flushed", popData, 0);
    sendBits(b, 48, -1);
    chk("R11 new frame no early end", early, 0);
    chk("R11 new frame end", sEnd, 1);
    chk("R11 new frame crc ok", sCrc, 0);
    for (int k = 0; k < 3; k++) begin
      popWord(v);
      chk("R11 new frame data", v, b[47 - 16*k -: 16]);
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_none();
    t_short(2'd1, 1'b0, 1'b0, "type1 good");
    t_short(2'd1, 1'b1, 1'b1, "type1 bad R4");
    t_short(2'd3, 1'b1, 1'b0, "type3 bad R6");
    t_long(1'b0, 39);
    t_long(1'b1, -1);
    t_timeout();
    t_abort();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule